// File: doc/BRIEF.md
# Trap-Return and Privilege State Unit

This unit sits beside the execute stage of a four-level privileged core. It watches a strobed 32-bit instruction word for the six fixed-encoding system instructions: environment call, breakpoint, and the user, supervisor, hypervisor and machine trap returns. For a return that is allowed at the current privilege, it works out three things from the status word held before the instruction. These are the next privilege, the updated status word and the redirect target. It then reports them, along with a request to drain the pipeline. Instructions that raise an exception report only a cause code.

The caller supplies the current privilege and status word, plus the saved machine and supervisor exception PCs. All results appear on registered outputs one cycle after the strobe. The unit keeps its own copy of the last committed privilege and status word. A synchronous reset sets that copy to machine privilege with an all-zero status word. Each return level has its own saved-PC input and its own previous-privilege and previous-enable fields. The enable bit that gets restored is the one selected by the saved previous privilege.

Privilege encoding: user 0, supervisor 1, hypervisor 2, machine 3. Status word layout: the per-level enable bits sit at bits 0..3 (user, supervisor, hypervisor, machine). The supervisor previous-enable is bit 5, the machine previous-enable is bit 7, the one-bit supervisor previous privilege is bit 8, and the two-bit machine previous privilege is bits 12:11.

Top module: `xret_priv_unit`

## Requirements
- R1: While reset is asserted, every pulse output is 0, exc_cause and rdr_pc are 0, new_prv is 3 (machine) and new_sts is 0.
- R2: An instruction is recognised only when all 32 bits equal one of these words: 0x00000073 (environment call), 0x00100073 (breakpoint), 0x00200073 (user return), 0x10200073 (supervisor return), 0x20200073 (hypervisor return) or 0x30200073 (machine return). Any other word produces no pulse, and new_prv, new_sts and rdr_pc keep their values.
- R3: A machine return at privilege 3 gives, one cycle later, a single-cycle rdr_vld, ser_pulse and sts_we, with rdr_pc equal to mepc.
- R4: On a machine return, let p be cur_sts[12:11]. In new_sts, bit p takes cur_sts[7], bit 7 becomes 0, bits 12:11 become 0, and every other bit equals cur_sts. new_prv becomes p.
- R5: A supervisor return at privilege 1, 2 or 3 gives, one cycle later, a single-cycle rdr_vld, ser_pulse and sts_we, with rdr_pc equal to sepc whatever the privilege.
- R6: On a supervisor return, let p be cur_sts[8] zero-extended. In new_sts, bit p takes cur_sts[5], bits 5 and 8 become 0, and every other bit equals cur_sts. new_prv becomes p.
- R7: A machine return below privilege 3, or a supervisor return at privilege 0, gives exc_vld with exc_cause 2 one cycle later. It gives no redirect, serialize or status write, and new_prv and new_sts hold.
- R8: User and hypervisor returns at any privilege give exc_vld with exc_cause 2 and change no state.
- R9: An environment call gives exc_vld with exc_cause 8 plus cur_prv. A breakpoint gives exc_vld with exc_cause 3. Neither redirects nor writes the status word.
- R10: With ins_vld low, no output pulses and no held output changes, whatever ins_word carries.
- R11: Every pulse output drops back to 0 in the cycle after the one for its instruction, unless a new strobe drives it again. Strobes on consecutive cycles each see the cur_prv and cur_sts presented with them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_vld | input | 1 | Instruction word is valid this cycle |
| ins_word | input | 32 | Instruction word |
| cur_prv | input | 2 | Current privilege (U0 S1 H2 M3) |
| cur_sts | input | 32 | Status word before the instruction |
| mepc | input | 32 | Machine saved exception PC |
| sepc | input | 32 | Supervisor saved exception PC |
| rdr_vld | output | 1 | Redirect pulse |
| rdr_pc | output | 32 | Redirect target, held between returns |
| ser_pulse | output | 1 | Pipeline serialize request |
| new_prv | output | 2 | Privilege after the last committed return |
| new_sts | output | 32 | Status word after the last committed return |
| sts_we | output | 1 | Status write enable pulse |
| exc_vld | output | 1 | Exception pulse |
| exc_cause | output | 4 | Exception cause code, 0 when no exception |

## Verification
Machine returns are applied with the saved previous privilege set to each of the four levels and the previous-enable both set and clear. This separates a correct indexed restore from one that writes a fixed bit or the wrong source bit. Supervisor returns are issued from supervisor, hypervisor and machine level to show that the target never follows the current level. Each return is also issued below its required level, and the user and hypervisor returns are tried, to check that exceptions leave the held state untouched. Words one bit away from each encoding, strobe-low cycles, and back-to-back returns over pseudo-random status words check the exact match and the use of the pre-instruction state.

// File: rtl/xret_pkg.sv
package xret_pkg;

   localparam int INSN_W = 32;
   localparam int PRV_W  = 2;
   localparam int N_PRV  = 4;

   typedef enum logic [PRV_W-1:0] {
      PRV_U = 2'd0,
      PRV_S = 2'd1,
      PRV_H = 2'd2,
      PRV_M = 2'd3
   } prv_e;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_ECALL,
      OP_EBREAK,
      OP_URET,
      OP_SRET,
      OP_HRET,
      OP_MRET
   } sysop_e;

   localparam logic [INSN_W-1:0] ENC_ECALL  = 32'h0000_0073;
   localparam logic [INSN_W-1:0] ENC_EBREAK = 32'h0010_0073;
   localparam logic [INSN_W-1:0] ENC_URET   = 32'h0020_0073;
   localparam logic [INSN_W-1:0] ENC_SRET   = 32'h1020_0073;
   localparam logic [INSN_W-1:0] ENC_HRET   = 32'h2020_0073;
   localparam logic [INSN_W-1:0] ENC_MRET   = 32'h3020_0073;

   localparam int CAUSE_ILLEGAL    = 2;
   localparam int CAUSE_BREAK      = 3;
   localparam int CAUSE_ECALL_BASE = 8;

endpackage

// File: rtl/xret_decode.sv
module xret_decode
   import xret_pkg::*;
#(
   parameter int CAUSE_W = 4
)(
   input  logic [INSN_W-1:0]  ins_word,
   input  logic [PRV_W-1:0]   cur_prv,
   output logic               take_ret,
   output logic               ret_is_m,
   output logic               raise_exc,
   output logic [CAUSE_W-1:0] exc_code
);

   sysop_e op;
   prv_e   prv;

   assign prv = prv_e'(cur_prv);

   always_comb begin
      case (ins_word)
         ENC_ECALL:  op = OP_ECALL;
         ENC_EBREAK: op = OP_EBREAK;
         ENC_URET:   op = OP_URET;
         ENC_SRET:   op = OP_SRET;
         ENC_HRET:   op = OP_HRET;
         ENC_MRET:   op = OP_MRET;
         default:    op = OP_NONE;
      endcase
   end

   always_comb begin
      take_ret  = 1'b0;
      ret_is_m  = 1'b0;
      raise_exc = 1'b0;
      exc_code  = '0;
      case (op)
         OP_MRET: begin
            if (prv == PRV_M) begin
               take_ret = 1'b1;
               ret_is_m = 1'b1;
            end else begin
               raise_exc = 1'b1;
               exc_code  = CAUSE_W'(CAUSE_ILLEGAL);
            end
         end
         OP_SRET: begin
            if (prv != PRV_U) begin
               take_ret = 1'b1;
            end else begin
               raise_exc = 1'b1;
               exc_code  = CAUSE_W'(CAUSE_ILLEGAL);
            end
         end
         OP_URET, OP_HRET: begin
            raise_exc = 1'b1;
            exc_code  = CAUSE_W'(CAUSE_ILLEGAL);
         end
         OP_ECALL: begin
            raise_exc = 1'b1;
            exc_code  = CAUSE_W'(CAUSE_ECALL_BASE) + CAUSE_W'(cur_prv);
         end
         OP_EBREAK: begin
            raise_exc = 1'b1;
            exc_code  = CAUSE_W'(CAUSE_BREAK);
         end
         default: begin
            take_ret = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/xret_sts_calc.sv
module xret_sts_calc
   import xret_pkg::*;
#(
   parameter int STS_W    = 32,
   parameter int IE_BASE  = 0,
   parameter int SPIE_POS = 5,
   parameter int MPIE_POS = 7,
   parameter int SPP_POS  = 8,
   parameter int MPP_LO   = 11
)(
   input  logic               sel_m,
   input  logic [STS_W-1:0]   cur_sts,
   output logic [STS_W-1:0]   nxt_sts,
   output logic [PRV_W-1:0]   nxt_prv
);

   logic [PRV_W-1:0] prev;
   logic             pie;
   logic [N_PRV-1:0] ie_new;

   assign prev = sel_m ? cur_sts[MPP_LO +: PRV_W] : {1'b0, cur_sts[SPP_POS]};
   assign pie  = sel_m ? cur_sts[MPIE_POS] : cur_sts[SPIE_POS];

   for (genvar gi = 0; gi < N_PRV; gi++) begin : g_ie
      assign ie_new[gi] = (prev == PRV_W'(gi)) ? pie : cur_sts[IE_BASE + gi];
   end

   always_comb begin
      nxt_sts = cur_sts;
      nxt_sts[IE_BASE +: N_PRV] = ie_new;
      if (sel_m) begin
         nxt_sts[MPIE_POS]        = 1'b0;
         nxt_sts[MPP_LO +: PRV_W] = PRV_U;
      end else begin
         nxt_sts[SPIE_POS] = 1'b0;
         nxt_sts[SPP_POS]  = 1'b0;
      end
   end

   assign nxt_prv = prev;

endmodule

// File: rtl/xret_priv_unit.sv
module xret_priv_unit
   import xret_pkg::*;
#(
   parameter int PC_W     = 32,
   parameter int STS_W    = 32,
   parameter int CAUSE_W  = 4,
   parameter int IE_BASE  = 0,
   parameter int SPIE_POS = 5,
   parameter int MPIE_POS = 7,
   parameter int SPP_POS  = 8,
   parameter int MPP_LO   = 11
)(
   input  logic                clk,
   input  logic                rst,
   input  logic                ins_vld,
   input  logic [INSN_W-1:0]   ins_word,
   input  logic [PRV_W-1:0]    cur_prv,
   input  logic [STS_W-1:0]    cur_sts,
   input  logic [PC_W-1:0]     mepc,
   input  logic [PC_W-1:0]     sepc,
   output logic                rdr_vld,
   output logic [PC_W-1:0]     rdr_pc,
   output logic                ser_pulse,
   output logic [PRV_W-1:0]    new_prv,
   output logic [STS_W-1:0]    new_sts,
   output logic                sts_we,
   output logic                exc_vld,
   output logic [CAUSE_W-1:0]  exc_cause
);

   localparam int IE_TOP   = IE_BASE + N_PRV - 1;
   localparam int MPP_TOP  = MPP_LO + PRV_W - 1;
   localparam int MAX_CODE = CAUSE_ECALL_BASE + N_PRV - 1;

   if (MPP_TOP >= STS_W || SPP_POS >= STS_W || MPIE_POS >= STS_W || SPIE_POS >= STS_W) begin : g_bad_fit
      $error("status field lies outside STS_W");
   end
   if ((SPIE_POS >= IE_BASE && SPIE_POS <= IE_TOP) || (MPIE_POS >= IE_BASE && MPIE_POS <= IE_TOP)) begin : g_bad_ovl
      $error("previous-enable field overlaps the enable bits");
   end
   if (MAX_CODE >= (1 << CAUSE_W)) begin : g_bad_cause
      $error("CAUSE_W too narrow for environment-call codes");
   end

   logic               take_ret;
   logic               ret_is_m;
   logic               raise_exc;
   logic [CAUSE_W-1:0] exc_code;
   logic [STS_W-1:0]   nxt_sts;
   logic [PRV_W-1:0]   nxt_prv;
   logic               fire_ret;
   logic               fire_exc;

   xret_decode #(.CAUSE_W(CAUSE_W)) u_dec (
      .ins_word  (ins_word),
      .cur_prv   (cur_prv),
      .take_ret  (take_ret),
      .ret_is_m  (ret_is_m),
      .raise_exc (raise_exc),
      .exc_code  (exc_code)
   );

   xret_sts_calc #(
      .STS_W    (STS_W),
      .IE_BASE  (IE_BASE),
      .SPIE_POS (SPIE_POS),
      .MPIE_POS (MPIE_POS),
      .SPP_POS  (SPP_POS),
      .MPP_LO   (MPP_LO)
   ) u_sts (
      .sel_m    (ret_is_m),
      .cur_sts  (cur_sts),
      .nxt_sts  (nxt_sts),
      .nxt_prv  (nxt_prv)
   );

   assign fire_ret = ins_vld & take_ret;
   assign fire_exc = ins_vld & raise_exc;

   always_ff @(posedge clk) begin
      if (rst) begin
         rdr_vld   <= 1'b0;
         ser_pulse <= 1'b0;
         sts_we    <= 1'b0;
         exc_vld   <= 1'b0;
         exc_cause <= '0;
         rdr_pc    <= '0;
         new_prv   <= PRV_M;
         new_sts   <= '0;
      end else begin
         rdr_vld   <= fire_ret;
         ser_pulse <= fire_ret;
         sts_we    <= fire_ret;
         exc_vld   <= fire_exc;
         exc_cause <= fire_exc ? exc_code : '0;
         if (fire_ret) begin
            rdr_pc  <= ret_is_m ? mepc : sepc;
            new_prv <= nxt_prv;
            new_sts <= nxt_sts;
         end
      end
   end

endmodule

// File: rtl/xret_priv_unit_chk.sv
module xret_priv_unit_chk
   import xret_pkg::*;
#(
   parameter int PC_W    = 32,
   parameter int STS_W   = 32,
   parameter int CAUSE_W = 4
)(
   input logic                clk,
   input logic                rst,
   input logic                ins_vld,
   input logic [INSN_W-1:0]   ins_word,
   input logic [PRV_W-1:0]    cur_prv,
   input logic [PC_W-1:0]     mepc,
   input logic [PC_W-1:0]     sepc,
   input logic                rdr_vld,
   input logic [PC_W-1:0]     rdr_pc,
   input logic                ser_pulse,
   input logic [PRV_W-1:0]    new_prv,
   input logic [STS_W-1:0]    new_sts,
   input logic                sts_we,
   input logic                exc_vld,
   input logic [CAUSE_W-1:0]  exc_cause
);

   AST_RDR_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
      (rdr_vld || exc_vld) |-> ($past(ins_vld) && !$past(rst))); // R10

   AST_NO_EXC_WITH_RDR: assert property (@(posedge clk) disable iff (rst)
      !(exc_vld && (rdr_vld || sts_we || ser_pulse))); // R7

   AST_STS_HOLD: assert property (@(posedge clk) disable iff (rst)
      !sts_we |-> ($stable(new_sts) && $stable(new_prv))); // R7

   AST_MRET_TARGET: assert property (@(posedge clk) disable iff (rst)
      (rdr_vld && $past(ins_word) == ENC_MRET) |-> rdr_pc == $past(mepc)); // R3

   AST_SRET_TARGET: assert property (@(posedge clk) disable iff (rst)
      (rdr_vld && $past(ins_word) == ENC_SRET) |-> rdr_pc == $past(sepc)); // R5

   AST_URET_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(ins_vld) && ($past(ins_word) == ENC_URET || $past(ins_word) == ENC_HRET))
      |-> (exc_vld && exc_cause == CAUSE_W'(CAUSE_ILLEGAL))); // R8

   AST_ECALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(ins_vld) && $past(ins_word) == ENC_ECALL)
      |-> (exc_vld && exc_cause == CAUSE_W'(CAUSE_ECALL_BASE) + CAUSE_W'($past(cur_prv)))); // R9

   AST_SER_WITH_RDR: assert property (@(posedge clk) disable iff (rst)
      ser_pulse |-> (rdr_vld && sts_we)); // R3

endmodule

bind xret_priv_unit xret_priv_unit_chk #(
   .PC_W    (PC_W),
   .STS_W   (STS_W),
   .CAUSE_W (CAUSE_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .ins_vld   (ins_vld),
   .ins_word  (ins_word),
   .cur_prv   (cur_prv),
   .mepc      (mepc),
   .sepc      (sepc),
   .rdr_vld   (rdr_vld),
   .rdr_pc    (rdr_pc),
   .ser_pulse (ser_pulse),
   .new_prv   (new_prv),
   .new_sts   (new_sts),
   .sts_we    (sts_we),
   .exc_vld   (exc_vld),
   .exc_cause (exc_cause)
);

// File: tb/xret_priv_unit_test.sv
`timescale 1ns/1ps
module xret_priv_unit_test;

   localparam logic [31:0] W_ECALL  = 32'h0000_0073;
   localparam logic [31:0] W_EBREAK = 32'h0010_0073;
   localparam logic [31:0] W_URET   = 32'h0020_0073;
   localparam logic [31:0] W_SRET   = 32'h1020_0073;
   localparam logic [31:0] W_HRET   = 32'h2020_0073;
   localparam logic [31:0] W_MRET   = 32'h3020_0073;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ins_vld = 1'b0;
   logic [31:0] ins_word = '0;
   logic [1:0]  cur_prv = 2'd3;
   logic [31:0] cur_sts = '0;
   logic [31:0] mepc = '0;
   logic [31:0] sepc = '0;
   logic        rdr_vld, ser_pulse, sts_we, exc_vld;
   logic [31:0] rdr_pc, new_sts;
   logic [1:0]  new_prv;
   logic [3:0]  exc_cause;

   always #2.5 clk = ~clk;

   xret_priv_unit uut (
      .clk(clk), .rst(rst), .ins_vld(ins_vld), .ins_word(ins_word),
      .cur_prv(cur_prv), .cur_sts(cur_sts), .mepc(mepc), .sepc(sepc),
      .rdr_vld(rdr_vld), .rdr_pc(rdr_pc), .ser_pulse(ser_pulse),
      .new_prv(new_prv), .new_sts(new_sts), .sts_we(sts_we),
      .exc_vld(exc_vld), .exc_cause(exc_cause)
   );

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // expected outputs for the cycle after the last applied vector
   bit          e_rdr = 0, e_ser = 0, e_we = 0, e_exc = 0;
   int          e_cause = 0;
   logic [31:0] e_pc = '0, e_sts = '0;
   int          e_prv = 3;
   string       pend_tag = "R1";

   task automatic compare();
      logic [73:0] got, exp;
      got = {rdr_vld, ser_pulse, sts_we, exc_vld, exc_cause, new_prv, rdr_pc, new_sts};
      exp = {e_rdr, e_ser, e_we, e_exc, 4'(e_cause), 2'(e_prv), e_pc, e_sts};
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", pend_tag, got, exp);
      end
   endtask

   task automatic model_ret(bit is_m, logic [31:0] s, logic [31:0] mp, logic [31:0] sp);
      int   p;
      logic en;
      logic [31:0] ns;
      p  = is_m ? int'(s[12:11]) : int'(s[8]);
      en = is_m ? s[7] : s[5];
      ns = s;
      ns[p] = en;
      if (is_m) begin ns[7] = 1'b0; ns[12:11] = 2'b00; end
      else      begin ns[5] = 1'b0; ns[8] = 1'b0; end
      e_rdr = 1; e_ser = 1; e_we = 1;
      e_prv = p; e_sts = ns; e_pc = is_m ? mp : sp;
   endtask

   task automatic illegal();
      e_exc = 1; e_cause = 2;
   endtask

   task automatic apply(string tag, bit v, logic [31:0] w, int p,
                        logic [31:0] s, logic [31:0] mp, logic [31:0] sp);
      @(negedge clk);
      compare();
      e_rdr = 0; e_ser = 0; e_we = 0; e_exc = 0; e_cause = 0;
      if (v) begin
         if (w == W_MRET)       begin if (p == 3) model_ret(1, s, mp, sp); else illegal(); end
         else if (w == W_SRET)  begin if (p >= 1) model_ret(0, s, mp, sp); else illegal(); end
         else if (w == W_URET || w == W_HRET) illegal();
         else if (w == W_ECALL) begin e_exc = 1; e_cause = 8 + p; end
         else if (w == W_EBREAK) begin e_exc = 1; e_cause = 3; end
      end
      pend_tag = tag;
      ins_vld = v; ins_word = w; cur_prv = 2'(p); cur_sts = s; mepc = mp; sepc = sp;
   endtask

   task automatic idle(string tag);
      apply(tag, 0, 32'h0, 0, 32'h0, 32'h0, 32'h0);
   endtask

   initial begin
      logic [31:0] lcg;
      repeat (3) @(posedge clk);
      @(negedge clk);
      compare();                       // R1 reset values while rst high
      rst = 1'b0;
      pend_tag = "R1";
      idle("R1");
      // R10 strobe low with a return word
      apply("R10", 0, W_MRET, 3, 32'h0000_1880, 32'hAAAA_0000, 32'h5555_0000);
      // R3 R4 machine return, previous privilege each level
      apply("R3", 1, W_MRET, 3, 32'h0000_0880, 32'h8000_1000, 32'h1);
      idle("R11");
      apply("R4", 1, W_MRET, 3, 32'h0000_1808, 32'h8000_2000, 32'h2);
      apply("R4", 1, W_MRET, 3, 32'h0000_1080, 32'h8000_3000, 32'h3);
      apply("R4", 1, W_MRET, 3, 32'hFFFF_0081, 32'h8000_4000, 32'h4);
      apply("R4", 1, W_MRET, 3, 32'h0000_1880, 32'h8000_5000, 32'h5);
      idle("R11");
      // R5 R6 supervisor return from S, H, M
      apply("R6", 1, W_SRET, 1, 32'h0000_0120, 32'h9, 32'h4000_0100);
      apply("R5", 1, W_SRET, 3, 32'h0000_1881, 32'h9, 32'h4000_0200);
      apply("R5", 1, W_SRET, 2, 32'h0000_0104, 32'h9, 32'h4000_0300);
      apply("R6", 1, W_SRET, 1, 32'h0F00_0022, 32'h9, 32'h4000_0400);
      // R7 returns below their level
      apply("R7", 1, W_MRET, 1, 32'h0000_1880, 32'h7777_0000, 32'h1);
      apply("R7", 1, W_MRET, 0, 32'h0000_1880, 32'h7777_0000, 32'h1);
      apply("R7", 1, W_MRET, 2, 32'h0000_1880, 32'h7777_0000, 32'h1);
      apply("R7", 1, W_SRET, 0, 32'h0000_0120, 32'h1, 32'h6666_0000);
      // R8 user and hypervisor returns
      apply("R8", 1, W_URET, 3, 32'h0000_0011, 32'h1, 32'h2);
      apply("R8", 1, W_HRET, 3, 32'h0000_0044, 32'h1, 32'h2);
      apply("R8", 1, W_URET, 0, 32'h0000_0011, 32'h1, 32'h2);
      apply("R8", 1, W_HRET, 2, 32'h0000_0044, 32'h1, 32'h2);
      // R9 environment call at each level, breakpoint
      for (int p = 0; p < 4; p++) apply("R9", 1, W_ECALL, p, 32'h0000_00FF, 32'h1, 32'h2);
      apply("R9", 1, W_EBREAK, 1, 32'h0000_00FF, 32'h1, 32'h2);
      apply("R9", 1, W_EBREAK, 3, 32'h0000_00FF, 32'h1, 32'h2);
      idle("R11");
      // R2 near misses
      apply("R2", 1, 32'h3020_0072, 3, 32'h0000_1880, 32'hDEAD_0000, 32'h1);
      apply("R2", 1, 32'h3020_0173, 3, 32'h0000_1880, 32'hDEAD_0000, 32'h1);
      apply("R2", 1, 32'h3030_0073, 3, 32'h0000_1880, 32'hDEAD_0000, 32'h1);
      apply("R2", 1, 32'h7020_0073, 3, 32'h0000_1880, 32'hDEAD_0000, 32'h1);
      apply("R2", 1, 32'h1020_0873, 1, 32'h0000_0120, 32'h1, 32'hBEEF_0000);
      apply("R2", 1, 32'h0000_0013, 3, 32'h0000_1880, 32'h1, 32'h2);
      // R11 back-to-back returns over pseudo-random status words
      lcg = 32'h1234_5678;
      for (int i = 0; i < 40; i++) begin
         lcg = lcg * 32'd1664525 + 32'd1013904223;
         apply("R11", 1, (i % 2 == 0) ? W_MRET : W_SRET, (i % 3 == 0) ? 1 : 3,
               lcg, lcg ^ 32'hF0F0_0000, ~lcg);
      end
      idle("R11");
      idle("R11");
      @(negedge clk);
      compare();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule